// File: doc/BRIEF.md
# Statically Scheduled Wide-Word Execution Engine

This block runs a program of wide instruction words, one word per clock. Each word has a separate slot for every functional unit. With the default mix there are two pipelined multipliers, two adders and one divider. Every unit reads two operands from its own small register file and writes its result back into that same file. The only path between units is a crossbar. Each crossbar output is steered by a field of the current word. It copies the value one unit writes back in that cycle into a chosen register of another unit's file.

The hardware checks no dependencies and never stalls. The program must already place every operation in the cycle where its operands are ready. When a local result and a crossbar delivery target the same unit's single write port in one cycle, the crossbar delivery is written and a sticky error flag is raised.

Before a run, software fills the instruction memory and the register files through a load port. It then pulses `start`. The engine has three states:
- IDLE is the state after reset.
- START moves IDLE to RUN and also DONE to RUN; it clears the program counter and the error flag.
- In RUN the engine fetches and issues one word per cycle at increasing addresses.
- HALT moves RUN to DONE once a word with the halt bit set has issued.

Multiplies already in flight keep draining in DONE. Register contents can be read at any time through an observation port.

Top module: `vliw_engine`

## Requirements
- R1: Word layout (61 bits): unit u owns bits [u*10 +: 10], where bit 0 is enable, bits 3:1 source A, bits 6:4 source B and bits 9:7 destination. Units 0 and 1 are multipliers, 2 and 3 adders, and 4 the divider. All enabled slots of one word execute in the same cycle, and the program counter advances by one every RUN cycle.
- R2: An adder writes A+B into its own file so that the sum is readable by a word issued one cycle later.
- R3: A multiplier accepts a new operation every cycle. Its product (low 16 bits) is written at the end of the third cycle after issue, so a word issued one or two cycles later still reads the old register value.
- R4: The divider writes the unsigned quotient A/B with a latency of one cycle; a zero divisor yields 16'hFFFF.
- R5: Crossbar field bits 59:50 hold valid (bit 50), source unit (53:51), destination unit (56:54) and destination register (59:57). It copies the value the source unit writes back in that same cycle, and it writes nothing when the source unit writes nothing in that cycle.
- R6: If a crossbar delivery and a local result reach one unit in the same cycle, the delivery is written, the local result is dropped, and `err` is set and held until the next start.
- R7: The halt bit is bit 60. The halting word still executes; the engine then enters DONE (`done`=1, `busy`=0) and issues no further words.
- R8: A start pulse in IDLE or DONE enters RUN at address 0 and clears `err`.
- R9: Loads are ignored while `busy`=1. Otherwise, with `ld_to_rf`=0 a load writes `ld_data` to instruction address `ld_addr`; with `ld_to_rf`=1 it writes `ld_data[15:0]` to register `ld_addr[2:0]` of unit `ld_unit`.
- R10: After reset `busy`, `done` and `err` are 0.
- R11: A slot whose enable bit is 0 writes nothing, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run at address 0 (ignored while busy) |
| ld_en | input | 1 | Load strobe |
| ld_to_rf | input | 1 | 0: instruction memory, 1: register file |
| ld_unit | input | 3 | Target unit for register loads |
| ld_addr | input | 4 | Instruction address or register index |
| ld_data | input | 61 | Instruction word or register value (low 16 bits) |
| obs_unit | input | 3 | Unit whose register is observed |
| obs_reg | input | 3 | Register index observed |
| obs_data | output | 16 | Observed register value |
| busy | output | 1 | Engine in RUN |
| done | output | 1 | Engine in DONE |
| err | output | 1 | Sticky write-port collision flag |

## Verification
The bench reads an operand one and two cycles after a multiply issues. A design whose product appears too early would return a nonzero value there. A crossbar transfer is scheduled in a cycle where its source unit writes nothing; a design that forwards stale data would overwrite the preloaded target. A collision is forced on purpose, and the bench checks that the local result is really lost, not merged or written twice. It also checks that a word placed after the halt leaves no trace, that divide-by-zero saturates, that a mid-run register load is rejected, and that the run length matches the halt position exactly.

// File: rtl/vliw_pkg.sv
package vliw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        K_MUL,
        K_ADD,
        K_DIV
    } unit_kind_t;

    // Units are numbered multipliers first, then adders, then dividers.
    function automatic unit_kind_t kind_of(int idx, int n_mul, int n_add);
        if (idx < n_mul)
            return K_MUL;
        else if (idx < n_mul + n_add)
            return K_ADD;
        else
            return K_DIV;
    endfunction

endpackage

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
    parameter int DATA_W = 16,
    parameter int REG_W  = 3
) (
    input  logic              clk,
    input  logic [REG_W-1:0]  ra0,
    input  logic [REG_W-1:0]  ra1,
    input  logic [REG_W-1:0]  ra_obs,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd_obs,
    input  logic              we,
    input  logic [REG_W-1:0]  wa,
    input  logic [DATA_W-1:0] wd
);
    localparam int DEPTH = 1 << REG_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[wa] <= wd;
    end

    assign rd0    = mem[ra0];
    assign rd1    = mem[ra1];
    assign rd_obs = mem[ra_obs];
endmodule

// File: rtl/vliw_mul_pipe.sv
module vliw_mul_pipe #(
    parameter int DATA_W = 16,
    parameter int REG_W  = 3,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [REG_W-1:0]  dst_i,
    output logic              wb_v_o,
    output logic [DATA_W-1:0] wb_d_o,
    output logic [REG_W-1:0]  wb_r_o
);
    // The write-back happens during the cycle after the last stage register,
    // so LAT-1 stages make the result readable LAT cycles after issue.
    localparam int STG = LAT - 1;

    logic              v_q [STG];
    logic [DATA_W-1:0] d_q [STG];
    logic [REG_W-1:0]  r_q [STG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STG; i++) begin
                v_q[i] <= 1'b0;
                d_q[i] <= '0;
                r_q[i] <= '0;
            end
        end else begin
            v_q[0] <= issue_i;
            d_q[0] <= a_i * b_i;
            r_q[0] <= dst_i;
            for (int i = 1; i < STG; i++) begin
                v_q[i] <= v_q[i-1];
                d_q[i] <= d_q[i-1];
                r_q[i] <= r_q[i-1];
            end
        end
    end

    assign wb_v_o = v_q[STG-1];
    assign wb_d_o = d_q[STG-1];
    assign wb_r_o = r_q[STG-1];
endmodule

// File: rtl/vliw_xbar.sv
module vliw_xbar #(
    parameter int DATA_W  = 16,
    parameter int REG_W   = 3,
    parameter int N_UNITS = 5,
    parameter int UID_W   = 3,
    parameter int N_OUT   = 1
) (
    input  logic              wb_v  [N_UNITS],
    input  logic [DATA_W-1:0] wb_d  [N_UNITS],
    input  logic [REG_W-1:0]  wb_r  [N_UNITS],
    input  logic              xv    [N_OUT],
    input  logic [UID_W-1:0]  xsrc  [N_OUT],
    input  logic [UID_W-1:0]  xdst  [N_OUT],
    input  logic [REG_W-1:0]  xreg  [N_OUT],
    output logic              fw_v  [N_UNITS],
    output logic [DATA_W-1:0] fw_d  [N_UNITS],
    output logic [REG_W-1:0]  fw_r  [N_UNITS],
    output logic              collide
);
    always_comb begin
        collide = 1'b0;
        for (int u = 0; u < N_UNITS; u++) begin
            fw_v[u] = wb_v[u];
            fw_d[u] = wb_d[u];
            fw_r[u] = wb_r[u];
            // Walk outputs from highest to lowest so output 0 has the last word.
            for (int k = N_OUT - 1; k >= 0; k--) begin
                if (xv[k] && (int'(xdst[k]) == u) && (int'(xsrc[k]) < N_UNITS)) begin
                    if (wb_v[int'(xsrc[k])]) begin
                        if (fw_v[u])
                            collide = 1'b1;
                        fw_v[u] = 1'b1;
                        fw_d[u] = wb_d[int'(xsrc[k])];
                        fw_r[u] = xreg[k];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vliw_engine.sv
module vliw_engine
    import vliw_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_W   = 3,
    parameter int PC_W    = 4,
    parameter int N_MUL   = 2,
    parameter int N_ADD   = 2,
    parameter int N_DIV   = 1,
    parameter int XB_OUTS = 1,
    parameter int MUL_LAT = 3,
    localparam int N_UNITS = N_MUL + N_ADD + N_DIV,
    localparam int UID_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int UF_W    = 1 + 3 * REG_W,
    localparam int XF_W    = 1 + 2 * UID_W + REG_W,
    localparam int XB_BASE = N_UNITS * UF_W,
    localparam int INSTR_W = XB_BASE + XB_OUTS * XF_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               ld_en,
    input  logic               ld_to_rf,
    input  logic [UID_W-1:0]   ld_unit,
    input  logic [PC_W-1:0]    ld_addr,
    input  logic [INSTR_W-1:0] ld_data,
    input  logic [UID_W-1:0]   obs_unit,
    input  logic [REG_W-1:0]   obs_reg,
    output logic [DATA_W-1:0]  obs_data,
    output logic               busy,
    output logic               done,
    output logic               err
);
    localparam int IMEM_DEPTH = 1 << PC_W;

    eng_state_t         state_q, state_d;
    logic [PC_W-1:0]    pc_q;
    logic               err_q;
    logic [INSTR_W-1:0] imem [IMEM_DEPTH];
    logic [INSTR_W-1:0] iw;
    logic               issue;
    logic               halt_bit;
    logic               start_ok;
    logic               xb_collide;

    logic              wb_v  [N_UNITS];
    logic [DATA_W-1:0] wb_d  [N_UNITS];
    logic [REG_W-1:0]  wb_r  [N_UNITS];
    logic              fw_v  [N_UNITS];
    logic [DATA_W-1:0] fw_d  [N_UNITS];
    logic [REG_W-1:0]  fw_r  [N_UNITS];
    logic [DATA_W-1:0] obs_rd [N_UNITS];
    logic              xv    [XB_OUTS];
    logic [UID_W-1:0]  xsrc  [XB_OUTS];
    logic [UID_W-1:0]  xdst  [XB_OUTS];
    logic [REG_W-1:0]  xreg  [XB_OUTS];

    assign issue    = (state_q == ST_RUN);
    assign iw       = imem[pc_q];
    assign halt_bit = iw[INSTR_W-1];
    assign start_ok = start && (state_q != ST_RUN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (halt_bit) state_d = ST_DONE;
            ST_DONE: if (start) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (start_ok)
                pc_q <= '0;
            else if (issue)
                pc_q <= pc_q + 1'b1;
            if (start_ok)
                err_q <= 1'b0;
            else if (issue && xb_collide)
                err_q <= 1'b1;
        end
    end
    assign err = err_q;

    always_ff @(posedge clk) begin
        if (ld_en && !ld_to_rf && !issue)
            imem[ld_addr] <= ld_data;
    end

    for (genvar k = 0; k < XB_OUTS; k++) begin : g_xfield
        localparam int XB = XB_BASE + k * XF_W;
        assign xv[k]   = issue & iw[XB];
        assign xsrc[k] = iw[XB + 1 +: UID_W];
        assign xdst[k] = iw[XB + 1 + UID_W +: UID_W];
        assign xreg[k] = iw[XB + 1 + 2 * UID_W +: REG_W];
    end

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        localparam int FB = u * UF_W;
        localparam unit_kind_t KIND = kind_of(u, N_MUL, N_ADD);

        logic              en;
        logic [REG_W-1:0]  sa, sb, sd;
        logic [DATA_W-1:0] opa, opb;
        logic              ld_hit, rf_we;
        logic [REG_W-1:0]  rf_wa;
        logic [DATA_W-1:0] rf_wd;

        assign en = issue & iw[FB];
        assign sa = iw[FB + 1 +: REG_W];
        assign sb = iw[FB + 1 + REG_W +: REG_W];
        assign sd = iw[FB + 1 + 2 * REG_W +: REG_W];

        if (KIND == K_MUL) begin : g_mul
            vliw_mul_pipe #(.DATA_W(DATA_W), .REG_W(REG_W), .LAT(MUL_LAT)) u_mul (
                .clk     (clk),
                .rst_n   (rst_n),
                .issue_i (en),
                .a_i     (opa),
                .b_i     (opb),
                .dst_i   (sd),
                .wb_v_o  (wb_v[u]),
                .wb_d_o  (wb_d[u]),
                .wb_r_o  (wb_r[u])
            );
        end else if (KIND == K_ADD) begin : g_add
            assign wb_v[u] = en;
            assign wb_d[u] = opa + opb;
            assign wb_r[u] = sd;
        end else begin : g_div
            assign wb_v[u] = en;
            assign wb_d[u] = (opb == '0) ? '1 : opa / opb;
            assign wb_r[u] = sd;
        end

        assign ld_hit = ld_en & ld_to_rf & ~issue & (ld_unit == UID_W'(u));
        assign rf_we  = fw_v[u] | ld_hit;
        assign rf_wa  = fw_v[u] ? fw_r[u] : ld_addr[REG_W-1:0];
        assign rf_wd  = fw_v[u] ? fw_d[u] : ld_data[DATA_W-1:0];

        vliw_regfile #(.DATA_W(DATA_W), .REG_W(REG_W)) u_rf (
            .clk    (clk),
            .ra0    (sa),
            .ra1    (sb),
            .ra_obs (obs_reg),
            .rd0    (opa),
            .rd1    (opb),
            .rd_obs (obs_rd[u]),
            .we     (rf_we),
            .wa     (rf_wa),
            .wd     (rf_wd)
        );
    end

    vliw_xbar #(
        .DATA_W (DATA_W),
        .REG_W  (REG_W),
        .N_UNITS(N_UNITS),
        .UID_W  (UID_W),
        .N_OUT  (XB_OUTS)
    ) u_xbar (
        .wb_v   (wb_v),
        .wb_d   (wb_d),
        .wb_r   (wb_r),
        .xv     (xv),
        .xsrc   (xsrc),
        .xdst   (xdst),
        .xreg   (xreg),
        .fw_v   (fw_v),
        .fw_d   (fw_d),
        .fw_r   (fw_r),
        .collide(xb_collide)
    );

    always_comb begin
        obs_data = '0;
        for (int u = 0; u < N_UNITS; u++)
            if (obs_unit == UID_W'(u))
                obs_data = obs_rd[u];
    end
endmodule

// File: rtl/vliw_engine_chk.sv
module vliw_engine_chk #(
    parameter int PC_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic [PC_W-1:0] pc,
    input logic            halt,
    input logic            collide
);
    p_state_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (pc == $past(pc) + 1'b1));

    p_halt_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && halt) |=> (done && !busy));

    p_start_pc0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && pc == '0 && !err));

    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(start && !busy)) |=> err);

    p_collide_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && collide) |=> err);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!busy && pc == $past(pc)));
endmodule

bind vliw_engine vliw_engine_chk #(.PC_W(PC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .pc     (pc_q),
    .halt   (halt_bit),
    .collide(xb_collide)
);

// File: tb/vliw_engine_tb_top.sv
module vliw_engine_tb_top;
    localparam int IW = 61;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start, ld_en, ld_to_rf;
    logic [2:0]    ld_unit;
    logic [3:0]    ld_addr;
    logic [IW-1:0] ld_data;
    logic [2:0]    obs_unit;
    logic [2:0]    obs_reg;
    logic [15:0]   obs_data;
    logic          busy, done, err;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    vliw_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en),
        .ld_to_rf(ld_to_rf), .ld_unit(ld_unit), .ld_addr(ld_addr),
        .ld_data(ld_data), .obs_unit(obs_unit), .obs_reg(obs_reg),
        .obs_data(obs_data), .busy(busy), .done(done), .err(err)
    );

    // {req[29:26], phase[25:22], unit[21:19], reg[18:16], value[15:0]}
    localparam int NV = 21;
    localparam logic [29:0] VEC [NV] = '{
        {4'd2, 4'd1, 3'd2, 3'd3, 16'd30},
        {4'd2, 4'd1, 3'd3, 3'd4, 16'd22},
        {4'd3, 4'd1, 3'd0, 3'd3, 16'd15},
        {4'd3, 4'd1, 3'd1, 3'd3, 16'd24},
        {4'd5, 4'd1, 3'd1, 3'd5, 16'd30},
        {4'd5, 4'd1, 3'd2, 3'd4, 16'd15},
        {4'd1, 4'd1, 3'd2, 3'd6, 16'd45},
        {4'd1, 4'd1, 3'd3, 3'd3, 16'd15},
        {4'd4, 4'd1, 3'd4, 3'd3, 16'd14},
        {4'd3, 4'd2, 3'd0, 3'd3, 16'd15},
        {4'd3, 4'd2, 3'd0, 3'd4, 16'd0},
        {4'd3, 4'd2, 3'd0, 3'd5, 16'd0},
        {4'd3, 4'd2, 3'd0, 3'd6, 16'd45},
        {4'd5, 4'd2, 3'd2, 3'd7, 16'd99},
        {4'd5, 4'd2, 3'd3, 3'd7, 16'd15},
        {4'd6, 4'd3, 3'd2, 3'd5, 16'd15},
        {4'd6, 4'd3, 3'd2, 3'd3, 16'd0},
        {4'd11, 4'd3, 3'd0, 3'd7, 16'd123},
        {4'd4, 4'd4, 3'd4, 3'd7, 16'hFFFF},
        {4'd9, 4'd5, 3'd4, 3'd1, 16'd100},
        {4'd7, 4'd6, 3'd2, 3'd7, 16'd0}
    };

    function automatic string tag_name(logic [3:0] n);
        case (n)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd9:  return "R9";
            4'd11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] op(logic [IW-1:0] w, int u, int a, int b, int d);
        logic [IW-1:0] r = w;
        r[u*10 +: 10] = {3'(d), 3'(b), 3'(a), 1'b1};
        return r;
    endfunction

    function automatic logic [IW-1:0] xb(logic [IW-1:0] w, int s, int du, int dr);
        logic [IW-1:0] r = w;
        r[50 +: 10] = {3'(dr), 3'(du), 3'(s), 1'b1};
        return r;
    endfunction

    task automatic ld_rf(int u, int r, int v);
        @(negedge clk);
        ld_en = 1'b1; ld_to_rf = 1'b1; ld_unit = 3'(u);
        ld_addr = 4'(r); ld_data = IW'(v);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic ld_im(int a, logic [IW-1:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_to_rf = 1'b0; ld_addr = 4'(a); ld_data = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int k = 0;
        while (!done && k < 200) begin
            @(negedge clk);
            k++;
        end
        if (!done) check(tag, 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_prog(string tag);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(tag);
    endtask

    task automatic rd_check(string tag, int u, int r, int exp);
        obs_unit = 3'(u);
        obs_reg  = 3'(r);
        #1;
        check(tag, int'(obs_data), exp);
    endtask

    task automatic walk_table(int p);
        for (int i = 0; i < NV; i++)
            if (int'(VEC[i][25:22]) == p)
                rd_check(tag_name(VEC[i][29:26]), int'(VEC[i][21:19]),
                         int'(VEC[i][18:16]), int'(VEC[i][15:0]));
    endtask

    initial begin
        #(200000 * 10);
        check("watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [IW-1:0] w;
        int cnt;
        rst_n = 1'b0; start = 1'b0; ld_en = 1'b0; ld_to_rf = 1'b0;
        ld_unit = '0; ld_addr = '0; ld_data = '0; obs_unit = '0; obs_reg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 err", int'(err), 0);

        // Operand preload
        ld_rf(0, 1, 3);   ld_rf(0, 2, 5);
        ld_rf(1, 1, 4);   ld_rf(1, 2, 6);
        ld_rf(2, 1, 10);  ld_rf(2, 2, 20);
        ld_rf(3, 1, 7);   ld_rf(3, 2, 8);
        ld_rf(4, 1, 100); ld_rf(4, 2, 7);

        // Phase 1: all units in parallel, adder forwarding, crossbar moves
        w = '0;
        w = op(w, 0, 1, 2, 3); w = op(w, 1, 1, 2, 3); w = op(w, 2, 1, 2, 3);
        w = op(w, 3, 1, 2, 3); w = op(w, 4, 1, 2, 3); w = xb(w, 2, 1, 5);
        ld_im(0, w);
        ld_im(1, op('0, 3, 3, 1, 4));
        ld_im(2, xb('0, 0, 2, 4));
        w = op('0, 2, 3, 4, 6); w[60] = 1'b1;
        ld_im(3, w);
        run_prog("R7 phase1 done");
        check("R7 done after halt", int'(done), 1);
        check("R7 busy after halt", int'(busy), 0);
        walk_table(1);

        // Phase 2: multiplier latency and idle-source crossbar
        ld_rf(0, 3, 0); ld_rf(2, 7, 99); ld_rf(3, 7, 77);
        ld_im(0, op('0, 0, 1, 2, 3));
        ld_im(1, xb(op('0, 0, 3, 1, 4), 0, 2, 7));
        ld_im(2, xb(op('0, 0, 3, 1, 5), 0, 3, 7));
        w = op('0, 0, 3, 1, 6); w[60] = 1'b1;
        ld_im(3, w);
        run_prog("R7 phase2 done");
        walk_table(2);

        // Phase 3: write-port collision, NOP slot with live fields
        ld_rf(2, 3, 0); ld_rf(2, 5, 0); ld_rf(0, 7, 123);
        w = op('0, 2, 1, 2, 3); w = op(w, 3, 1, 2, 3); w = xb(w, 3, 2, 5);
        w[0 +: 10] = {3'd7, 3'd2, 3'd1, 1'b0};
        w[60] = 1'b1;
        ld_im(0, w);
        run_prog("R7 phase3 done");
        check("R6 err set", int'(err), 1);
        walk_table(3);

        // Phase 4: divide by zero; start clears err
        ld_rf(4, 6, 0); ld_rf(4, 7, 5);
        w = op('0, 4, 1, 6, 7); w[60] = 1'b1;
        ld_im(0, w);
        run_prog("R7 phase4 done");
        check("R8 err cleared", int'(err), 0);
        walk_table(4);

        // Phase 5: load during run is ignored; run length follows halt position
        for (int a = 0; a < 5; a++) ld_im(a, '0);
        w = '0; w[60] = 1'b1;
        ld_im(5, w);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ld_en = 1'b1; ld_to_rf = 1'b1; ld_unit = 3'd4; ld_addr = 4'd1; ld_data = IW'(555);
        @(negedge clk);
        ld_en = 1'b0;
        cnt = 2;
        while (!done && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        check("R7 run length", cnt, 7);
        repeat (4) @(negedge clk);
        walk_table(5);

        // Phase 6: word after halt never issues
        ld_rf(2, 7, 0);
        w = '0; w[60] = 1'b1;
        ld_im(0, w);
        ld_im(1, op('0, 2, 1, 2, 7));
        run_prog("R7 phase6 done");
        repeat (3) @(negedge clk);
        check("R7 stays done", int'(done), 1);
        walk_table(6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule